// File: doc/BRIEF.md
# Triggered Multi-Channel Scan Sequencer

The sequencer runs one scan of an analog front end per trigger pulse. A mask names the scan slots to convert. The block visits the set slots from the lowest index upward. For each slot it asks the conversion engine below it for one 8-bit sample, giving a channel number and a single-ended or differential flag. The samples are packed with no gaps into a record, and a 64-bit time value is appended. The time value is the one on `ts_now` at the edge that took the trigger. The record leaves on a byte stream.

The slot space has two parts. The first `N_IN` slots are the single-ended inputs. The slots after them are the adjacent input pairs, each pair present in both polarities. With `N_IN` equal to 1 there is no multiplexer, and the single slot is the differential pair of inputs 0 and 1. The conversion engine is shared with a one-shot read port. That port is served only while no scan is in progress, so its requests never fall between the conversions of a scan.

The output stream uses valid/ready. A byte moves on a clock edge where both `m_valid` and `m_ready` are high. While `m_ready` is low, `m_valid`, `m_data` and `m_last` hold their values. The sink may keep `m_ready` low for any number of cycles, and the sequencer waits without losing a byte.

Top module: `scan_sequencer`

## Requirements
- R1: During and after reset, `m_valid`, `conv_req`, `scan_done` and `ss_done` are low until a trigger or a one-shot request arrives.
- R2: A slot `i` below `N_IN` converts single-ended input `i`: `conv_chan` = i and `conv_diff` = 0.
- R3: A slot `N_IN + d` converts a differential pair with `conv_diff` = 1. `conv_chan` = d is the positive input and d XOR 1 is the negative input, so the pairs run (0,1), (1,0), (2,3), (3,2) and so on.
- R4: Each set mask bit gives exactly one conversion, in ascending slot order. `conv_req` stays high, with `conv_chan` and `conv_diff` unchanged, until the cycle where `conv_done` is high.
- R5: Record byte k is the sample of the k-th set slot, counted from the lowest slot. Disabled slots leave no gap.
- R6: After the samples come zero bytes up to the next multiple of 8. Then come the 8 bytes of the time value latched at the trigger, least significant byte first.
- R7: A byte moves when `m_valid` and `m_ready` are both high. A stalled byte is held stable. `m_last` is high only on the last time-value byte, so the record length is that padded sample count plus 8.
- R8: One cycle after the final byte moves, `scan_done` pulses for one cycle with `scan_fail` low.
- R9: If `conv_err` is high together with `conv_done` during a scan, no further slot is converted and no record byte is offered. `scan_done` and `scan_fail` pulse together in the next cycle.
- R10: A trigger that arrives while a scan is converting, or while its record has not been fully accepted, has no effect.
- R11: When idle, a held `ss_req` starts one conversion of `ss_chan`/`ss_diff`. Its sample and error flag appear on `ss_data`/`ss_err`, with a one-cycle `ss_done` pulse. If a trigger arrives in the same cycle, the trigger wins, and the one-shot read is served after that scan ends.
- R12: An empty mask gives a record of the 8 time-value bytes alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig | input | 1 | One-cycle scan start |
| scan_mask | input | NIDX | Slot enables, sampled with the trigger |
| ts_now | input | 8*TSB | Free-running time value |
| ss_req | input | 1 | One-shot read request, held until `ss_done` |
| ss_chan | input | CW | One-shot channel |
| ss_diff | input | 1 | One-shot differential flag |
| ss_done | output | 1 | One-shot result pulse |
| ss_data | output | 8 | One-shot sample |
| ss_err | output | 1 | One-shot error flag |
| conv_req | output | 1 | Conversion request to the engine |
| conv_chan | output | CW | Requested channel (positive input when differential) |
| conv_diff | output | 1 | Requested mode, 1 = differential |
| conv_done | input | 1 | Engine result strobe |
| conv_data | input | 8 | Engine sample |
| conv_err | input | 1 | Engine error, valid with `conv_done` |
| m_valid | output | 1 | Record byte valid |
| m_data | output | 8 | Record byte |
| m_last | output | 1 | Final record byte |
| m_ready | input | 1 | Sink ready |
| scan_done | output | 1 | Scan finished or aborted |
| scan_fail | output | 1 | Set with `scan_done` on abort |

## Verification
The hardest states to reach from the ports are an error in the middle of a scan and a trigger that lands while an earlier record is held back by the sink. The bench's conversion-engine model raises the error only for one chosen channel and polarity. It uses a mask that has set slots on both sides of that pair. It then checks that the later slots are never requested and that no byte is offered. For the second case the sink keeps `m_ready` low and the bench fires extra triggers, both during the conversions and while the first byte sits stalled. It then checks that only the first record comes out and that no later conversion starts.

// File: rtl/scanseq_pkg.sv
package scanseq_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_PICK,
    SQ_CONV,
    SQ_SEND,
    SQ_SOLO
  } sq_state_t;

  // Slot count: single-ended inputs plus both polarities of each pair,
  // or one differential slot when there is no multiplexer.
  function automatic int unsigned scan_slots(input int unsigned inputs);
    return (inputs == 1) ? 1 : 2 * inputs;
  endfunction

  function automatic int unsigned bits_for(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/scan_index_map.sv
module scan_index_map
  import scanseq_pkg::*;
#(
  parameter int unsigned N_IN = 8,
  parameter int unsigned IW   = 4,
  parameter int unsigned CW   = 3
) (
  input  logic [IW-1:0] slot,
  output logic [CW-1:0] chan,
  output logic          diff
);

  localparam bit NO_MUX = (N_IN == 1);

  always_comb begin
    if (NO_MUX) begin
      chan = '0;
      diff = 1'b1;
    end else if (slot < IW'(N_IN)) begin
      chan = CW'(slot);
      diff = 1'b0;
    end else begin
      // pair slot d: positive input d, negative input d^1
      chan = CW'(slot - IW'(N_IN));
      diff = 1'b1;
    end
  end

endmodule

// File: rtl/scan_mask_pick.sv
module scan_mask_pick #(
  parameter int unsigned W  = 16,
  parameter int unsigned IW = 4
) (
  input  logic [W-1:0]  pend,
  output logic          any,
  output logic [IW-1:0] first
);

  // lowest pending slot wins, giving ascending order
  always_comb begin
    any   = |pend;
    first = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (pend[i]) first = IW'(i);
    end
  end

endmodule

// File: rtl/scan_record_mux.sv
module scan_record_mux #(
  parameter int unsigned NIDX = 16,
  parameter int unsigned TSB  = 8,
  parameter int unsigned CNTW = 5,
  parameter int unsigned PW   = 5
) (
  input  logic [NIDX*8-1:0] samples,
  input  logic [CNTW-1:0]   count,
  input  logic [TSB*8-1:0]  stamp,
  input  logic [PW-1:0]     pos,
  output logic [7:0]        byte_o,
  output logic              last_o
);

  logic [PW-1:0] pad_len;
  logic [PW-1:0] ts_off;
  logic [7:0]    smp_byte;
  logic [7:0]    ts_byte;

  assign pad_len  = (PW'(count) + PW'(TSB - 1)) & ~PW'(TSB - 1);
  assign ts_off   = pos - pad_len;
  assign smp_byte = 8'(samples >> {pos, 3'b000});
  assign ts_byte  = 8'(stamp >> {ts_off, 3'b000});
  assign last_o   = (pos == pad_len + PW'(TSB - 1));

  always_comb begin
    if (pos < pad_len) byte_o = (pos < PW'(count)) ? smp_byte : 8'h00;
    else               byte_o = ts_byte;
  end

endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
  import scanseq_pkg::*;
#(
  parameter int unsigned N_IN = 8,
  parameter int unsigned TSB  = 8,
  localparam int unsigned NIDX = scan_slots(N_IN),
  localparam int unsigned CW   = bits_for(N_IN),
  localparam int unsigned IW   = bits_for(NIDX),
  localparam int unsigned CNTW = $clog2(NIDX + 1),
  localparam int unsigned PW   = $clog2(NIDX + 2 * TSB),
  localparam int unsigned TSW  = TSB * 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trig,
  input  logic [NIDX-1:0] scan_mask,
  input  logic [TSW-1:0]  ts_now,
  input  logic            ss_req,
  input  logic [CW-1:0]   ss_chan,
  input  logic            ss_diff,
  output logic            ss_done,
  output logic [7:0]      ss_data,
  output logic            ss_err,
  output logic            conv_req,
  output logic [CW-1:0]   conv_chan,
  output logic            conv_diff,
  input  logic            conv_done,
  input  logic [7:0]      conv_data,
  input  logic            conv_err,
  output logic            m_valid,
  output logic [7:0]      m_data,
  output logic            m_last,
  input  logic            m_ready,
  output logic            scan_done,
  output logic            scan_fail
);

  sq_state_t         state;
  logic [NIDX-1:0]   pend;
  logic [IW-1:0]     cur_slot;
  logic [CNTW-1:0]   count;
  logic [TSW-1:0]    stamp;
  logic [PW-1:0]     pos;
  logic [CW-1:0]     solo_chan;
  logic              solo_diff;
  logic [NIDX*8-1:0] samples;

  logic              pick_any;
  logic [IW-1:0]     pick_slot;
  logic [CW-1:0]     map_chan;
  logic              map_diff;
  logic              store_en;

  scan_mask_pick #(.W(NIDX), .IW(IW)) u_pick (
    .pend  (pend),
    .any   (pick_any),
    .first (pick_slot)
  );

  scan_index_map #(.N_IN(N_IN), .IW(IW), .CW(CW)) u_map (
    .slot (cur_slot),
    .chan (map_chan),
    .diff (map_diff)
  );

  scan_record_mux #(.NIDX(NIDX), .TSB(TSB), .CNTW(CNTW), .PW(PW)) u_rec (
    .samples (samples),
    .count   (count),
    .stamp   (stamp),
    .pos     (pos),
    .byte_o  (m_data),
    .last_o  (m_last)
  );

  assign conv_req  = (state == SQ_CONV) || (state == SQ_SOLO);
  assign conv_chan = (state == SQ_SOLO) ? solo_chan : map_chan;
  assign conv_diff = (state == SQ_SOLO) ? solo_diff : map_diff;
  assign m_valid   = (state == SQ_SEND);
  assign store_en  = (state == SQ_CONV) && conv_done && !conv_err;

  // one byte register per slot, written at the next free position
  for (genvar g = 0; g < NIDX; g++) begin : g_slot
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             q <= '0;
      else if (store_en && count == CNTW'(g)) q <= conv_data;
    end
    assign samples[g*8 +: 8] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SQ_IDLE;
      pend      <= '0;
      cur_slot  <= '0;
      count     <= '0;
      stamp     <= '0;
      pos       <= '0;
      solo_chan <= '0;
      solo_diff <= 1'b0;
      scan_done <= 1'b0;
      scan_fail <= 1'b0;
      ss_done   <= 1'b0;
      ss_data   <= '0;
      ss_err    <= 1'b0;
    end else begin
      scan_done <= 1'b0;
      scan_fail <= 1'b0;
      ss_done   <= 1'b0;
      unique case (state)
        SQ_IDLE: begin
          if (trig) begin
            pend  <= scan_mask;
            stamp <= ts_now;
            count <= '0;
            state <= SQ_PICK;
          end else if (ss_req) begin
            solo_chan <= ss_chan;
            solo_diff <= ss_diff;
            state     <= SQ_SOLO;
          end
        end
        SQ_PICK: begin
          if (pick_any) begin
            cur_slot <= pick_slot;
            pend     <= pend & ~(NIDX'(1) << pick_slot);
            state    <= SQ_CONV;
          end else begin
            pos   <= '0;
            state <= SQ_SEND;
          end
        end
        SQ_CONV: begin
          if (conv_done) begin
            if (conv_err) begin
              scan_done <= 1'b1;
              scan_fail <= 1'b1;
              state     <= SQ_IDLE;
            end else begin
              count <= count + 1'b1;
              state <= SQ_PICK;
            end
          end
        end
        SQ_SEND: begin
          if (m_ready) begin
            if (m_last) begin
              scan_done <= 1'b1;
              state     <= SQ_IDLE;
            end else begin
              pos <= pos + 1'b1;
            end
          end
        end
        SQ_SOLO: begin
          if (conv_done) begin
            ss_done <= 1'b1;
            ss_data <= conv_data;
            ss_err  <= conv_err;
            state   <= SQ_IDLE;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/scan_sequencer_chk.sv
module scan_sequencer_chk #(
  parameter int unsigned CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          m_valid,
  input logic          m_ready,
  input logic [7:0]    m_data,
  input logic          m_last,
  input logic          conv_req,
  input logic          conv_done,
  input logic [CW-1:0] conv_chan,
  input logic          conv_diff,
  input logic          scan_done,
  input logic          scan_fail
);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_last));

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req && !conv_done |=> conv_req && $stable(conv_chan) && $stable(conv_diff));

  // R8
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_ready && m_last |=> scan_done && !scan_fail);

  // R9
  no_record_after_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_fail |=> !m_valid);

  // R9
  fail_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_fail |-> scan_done);

endmodule

bind scan_sequencer scan_sequencer_chk #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .m_valid   (m_valid),
  .m_ready   (m_ready),
  .m_data    (m_data),
  .m_last    (m_last),
  .conv_req  (conv_req),
  .conv_done (conv_done),
  .conv_chan (conv_chan),
  .conv_diff (conv_diff),
  .scan_done (scan_done),
  .scan_fail (scan_fail)
);

// File: tb/scan_sequencer_tb.sv
module scan_sequencer_tb;

  localparam int NI = 8;
  localparam int NX = 16;
  localparam int NV = 8;
  localparam logic [15:0] VEC_MASK [NV] = '{16'h0001, 16'h8000, 16'hFFFF, 16'h0000,
                                            16'h0A5C, 16'hFF00, 16'h00FF, 16'h4102};
  localparam int VEC_RDY [NV] = '{0, 1, 2, 0, 3, 1, 0, 2};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig = 1'b0;
  logic [15:0] scan_mask = '0;
  logic [63:0] ts_now = 64'h1122_3344_5566_7700;
  logic        ss_req = 1'b0;
  logic [2:0]  ss_chan = '0;
  logic        ss_diff = 1'b0;
  logic        ss_done, ss_err, conv_req, conv_diff;
  logic [7:0]  ss_data;
  logic [2:0]  conv_chan;
  logic        conv_done, conv_err;
  logic [7:0]  conv_data;
  logic        m_valid, m_last;
  logic [7:0]  m_data;
  logic        m_ready = 1'b0;
  logic        scan_done, scan_fail;

  always #10 clk = ~clk;

  scan_sequencer #(.N_IN(NI), .TSB(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .trig(trig), .scan_mask(scan_mask), .ts_now(ts_now),
    .ss_req(ss_req), .ss_chan(ss_chan), .ss_diff(ss_diff), .ss_done(ss_done),
    .ss_data(ss_data), .ss_err(ss_err), .conv_req(conv_req), .conv_chan(conv_chan),
    .conv_diff(conv_diff), .conv_done(conv_done), .conv_data(conv_data),
    .conv_err(conv_err), .m_valid(m_valid), .m_data(m_data), .m_last(m_last),
    .m_ready(m_ready), .scan_done(scan_done), .scan_fail(scan_fail)
  );

  int n_chk = 0;
  int n_fail = 0;
  int salt = 0;
  bit err_armed = 1'b0;
  int err_ch = 0;
  bit err_df = 1'b0;
  int log_n = 0;
  int log_ch [512];
  bit log_df [512];
  int done_cnt = 0, fail_cnt = 0, ss_cnt = 0, valid_cnt = 0;
  logic [7:0] rec [64];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] model(input int ch, input bit df, input int s);
    return {df, 3'(ch), 4'(s)};
  endfunction

  // slot-to-input mapping taken from R2 and R3
  function automatic void slot_map(input int idx, output int ch, output bit df);
    if (idx < NI) begin ch = idx; df = 1'b0; end
    else begin ch = idx - NI; df = 1'b1; end
  endfunction

  initial forever begin
    @(negedge clk);
    ts_now = ts_now + 64'd1;
  end

  // conversion engine model: answers two cycles after a request
  initial begin
    int lat;
    lat = 0;
    conv_done = 1'b0; conv_err = 1'b0; conv_data = '0;
    forever begin
      @(negedge clk);
      if (conv_done) begin
        conv_done = 1'b0; conv_err = 1'b0; lat = 0;
      end else if (conv_req) begin
        lat++;
        if (lat == 2) begin
          if (log_n < 512) begin
            log_ch[log_n] = int'(conv_chan);
            log_df[log_n] = conv_diff;
          end
          log_n++;
          conv_data = model(int'(conv_chan), conv_diff, salt);
          conv_err  = err_armed && int'(conv_chan) == err_ch && conv_diff == err_df;
          conv_done = 1'b1;
        end
      end
    end
  end

  initial forever begin
    @(negedge clk);
    #2;
    if (scan_done) done_cnt++;
    if (scan_done && scan_fail) fail_cnt++;
    if (ss_done) ss_cnt++;
    if (m_valid) valid_cnt++;
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "WD", "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  task automatic trig_pulse(input logic [15:0] m, input bit with_ss,
                            output longint ts_e, output int base);
    @(negedge clk);
    salt++;
    trig = 1'b1;
    scan_mask = m;
    if (with_ss) ss_req = 1'b1;
    base = log_n;
    #1 ts_e = longint'(ts_now);
    @(negedge clk);
    trig = 1'b0;
  endtask

  task automatic drain(input int mode, output int n, output int stall_bad);
    int cyc;
    bit prev_stall;
    logic [7:0] pd;
    logic pl;
    n = 0; stall_bad = 0; prev_stall = 1'b0; pd = '0; pl = 1'b0; cyc = 0;
    for (int it = 0; it < 800; it++) begin
      @(negedge clk);
      m_ready = (mode == 0) ? 1'b1 : ((cyc % (mode + 1)) != 0);
      cyc++;
      #1;
      if (prev_stall && (!m_valid || m_data != pd || m_last != pl)) stall_bad++;
      prev_stall = m_valid && !m_ready;
      pd = m_data; pl = m_last;
      if (m_valid && m_ready) begin
        if (n < 64) rec[n] = m_data;
        n++;
        if (m_last) break;
      end
    end
  endtask

  task automatic check_record(input logic [15:0] m, input longint ts_e, input int base,
                              input int n, input int stall_bad, input int s);
    logic [7:0] exp [64];
    int k, pad, elen, ch, bad_data, bad_tail, bad_log;
    bit df;
    k = 0; bad_data = 0; bad_tail = 0; bad_log = 0;
    for (int idx = 0; idx < NX; idx++) begin
      if (m[idx]) begin
        slot_map(idx, ch, df);
        exp[k] = model(ch, df, s);
        if (log_n - base > k && (log_ch[base + k] != ch || log_df[base + k] != df)) bad_log++;
        k++;
      end
    end
    pad  = ((k + 7) / 8) * 8;
    elen = pad + 8;
    for (int i = k; i < pad; i++) exp[i] = 8'h00;
    for (int i = 0; i < 8; i++) exp[pad + i] = 8'(ts_e >> (8 * i));
    // R2 R3 R4: requested inputs in ascending slot order, one per set bit
    check(bad_log == 0 && (log_n - base) == k, "R4", $sformatf("order mask %h", m),
          log_n - base, k);
    // R7: record length ends at m_last
    check(n == elen, "R7", $sformatf("length mask %h", m), n, elen);
    for (int i = 0; i < k && i < n; i++) if (rec[i] != exp[i]) bad_data++;
    // R5: densely packed samples
    check(bad_data == 0, "R5", $sformatf("samples mask %h", m), bad_data, 0);
    for (int i = k; i < elen && i < n; i++) if (rec[i] != exp[i]) bad_tail++;
    // R6 / R12: zero padding and time value, low byte first
    check(bad_tail == 0, (k == 0) ? "R12" : "R6", $sformatf("pad/stamp mask %h", m),
          bad_tail, 0);
    check(stall_bad == 0, "R7", $sformatf("stall hold mask %h", m), stall_bad, 0);
  endtask

  task automatic run_scan(input logic [15:0] m, input int mode);
    longint ts_e;
    int base, d0, f0, n, sb;
    trig_pulse(m, 1'b0, ts_e, base);
    d0 = done_cnt; f0 = fail_cnt;
    drain(mode, n, sb);
    check_record(m, ts_e, base, n, sb, salt);
    @(negedge clk);
    #3;
    m_ready = 1'b0;
    // R8: one done pulse, no fail
    check(done_cnt == d0 + 1 && fail_cnt == f0, "R8", $sformatf("done mask %h", m),
          done_cnt - d0, 1);
  endtask

  initial begin
    longint ts1;
    int base, d0, f0, v0, s0, n, sb;

    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    check(!m_valid && !conv_req && !scan_done && !ss_done, "R1", "in reset",
          {m_valid, conv_req, scan_done, ss_done}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    check(!m_valid && !conv_req && !scan_done && !ss_done, "R1", "after reset",
          {m_valid, conv_req, scan_done, ss_done}, 0);

    for (int v = 0; v < NV; v++) run_scan(VEC_MASK[v], VEC_RDY[v]);

    // R9: error on the (2,3) pair, slot 10; slot 11 must never be requested
    err_armed = 1'b1; err_ch = 2; err_df = 1'b1;
    @(negedge clk);
    m_ready = 1'b1;
    v0 = valid_cnt; d0 = done_cnt; f0 = fail_cnt;
    trig_pulse(16'h0C05, 1'b0, ts1, base);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      #3;
      if (fail_cnt != f0) break;
    end
    repeat (20) @(negedge clk);
    #3;
    check(fail_cnt == f0 + 1 && done_cnt == d0 + 1, "R9", "abort pulse", fail_cnt - f0, 1);
    check(valid_cnt == v0, "R9", "no record after abort", valid_cnt - v0, 0);
    check(log_n - base == 3 && log_ch[base + 2] == 2 && log_df[base + 2],
          "R9", "conversions before abort", log_n - base, 3);
    err_armed = 1'b0;
    m_ready = 1'b0;
    run_scan(16'h0C05, 0);

    // R10: extra triggers during conversion and during a stalled record
    trig_pulse(16'h0003, 1'b0, ts1, base);
    d0 = done_cnt;
    repeat (2) @(negedge clk);
    trig = 1'b1; scan_mask = 16'hFFFF;
    @(negedge clk);
    trig = 1'b0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      #1;
      if (m_valid) break;
    end
    @(negedge clk);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    repeat (4) @(negedge clk);
    drain(0, n, sb);
    check_record(16'h0003, ts1, base, n, sb, salt);
    @(negedge clk);
    #3;
    m_ready = 1'b0;
    v0 = valid_cnt;
    repeat (40) @(negedge clk);
    #3;
    check(done_cnt == d0 + 1, "R10", "single record", done_cnt - d0, 1);
    check(log_n - base == 2 && valid_cnt == v0, "R10", "no scan from ignored trigger",
          log_n - base, 2);

    // R11: one-shot read while idle
    @(negedge clk);
    ss_chan = 3'd5; ss_diff = 1'b0; ss_req = 1'b1;
    base = log_n; s0 = ss_cnt;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      #3;
      if (ss_cnt != s0) break;
    end
    ss_req = 1'b0;
    check(ss_cnt == s0 + 1 && ss_data == model(5, 1'b0, salt) && !ss_err, "R11",
          "idle one-shot", ss_data, model(5, 1'b0, salt));
    check(log_n - base == 1 && log_ch[base] == 5 && !log_df[base], "R11",
          "idle one-shot request", log_ch[base], 5);

    // R11: trigger and one-shot in the same cycle; scan first
    ss_chan = 3'd6; ss_diff = 1'b1;
    s0 = ss_cnt;
    trig_pulse(16'h0300, 1'b1, ts1, base);
    drain(1, n, sb);
    check(ss_cnt == s0, "R11", "one-shot held during scan", ss_cnt - s0, 0);
    check_record(16'h0300, ts1, base, n, sb, salt);
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      #3;
      m_ready = 1'b0;
      if (ss_cnt != s0) break;
    end
    ss_req = 1'b0;
    check(ss_cnt == s0 + 1 && ss_data == model(6, 1'b1, salt), "R11",
          "one-shot after scan", ss_data, model(6, 1'b1, salt));
    check(log_n - base == 3 && log_ch[base + 2] == 6 && log_df[base + 2], "R11",
          "one-shot request after scan", log_n - base, 3);

    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule